// File: doc/BRIEF.md
# Power Management Function Decoder

This block holds the configuration state of a power-management PCI function and uses it to decode I/O cycles and to raise the system control interrupt. A byte-wide configuration port reaches two relocatable I/O base registers. The first places a 128-byte power-management window and the second places a 16-byte SMBus window. Each window has its own enable bit at a separate configuration byte. Every I/O address strobe is compared against both windows, and the two hit outputs tell the surrounding fabric which function claims the cycle.

The block also keeps four event status bits, a matching enable nibble and the interrupt-pin field. Event sources pulse `evt_set` to latch a status bit. Software clears a status bit by writing a 1 to it. The registered interrupt output `sci` is high while any enabled status bit is set and the interrupt-pin field is non-zero.

The event bit order is: bit 0 timer, bit 1 global lock, bit 2 power button, bit 3 RTC alarm.

Top module: `pm_func_decode`

## Requirements
- R1: Bytes 0x48..0x4B hold the power-management base. A read of byte 0x48 returns written bit 7, zeros in bits 6:1 and a 1 in bit 0. Byte 0x49 returns all eight written bits. Bytes 0x4A and 0x4B read 0.
- R2: Bytes 0x90..0x93 hold the SMBus base. A read of byte 0x90 returns written bits 7:4, zeros in bits 3:1 and a 1 in bit 0. Byte 0x91 returns all eight written bits. Bytes 0x92 and 0x93 read 0.
- R3: After reset the following hold:
  - bytes 0x48 and 0x90 read 0x01; bytes 0x49, 0x91, 0x41, 0xD2, 0x44 and 0x45 read 0;
  - the interrupt-pin byte 0x3D reads 0x01;
  - neither window hits and `sci` is 0.
- R4: A write to byte 0xD2 keeps only its low four bits. Bits 7:4 read back as 0.
- R5: `pm_hit` is 1 in the same cycle as the strobe only when all of these hold:
  - `io_strobe` and `io_byte` are both 1;
  - bit 7 of byte 0x41 is set;
  - `io_addr` lies in [base, base+128).
  A multi-byte access (`io_byte`=0) never hits this window.
- R6: `smb_hit` is 1 in the same cycle as the strobe only when all of these hold:
  - `io_strobe` is 1;
  - bit 0 of byte 0xD2 is set;
  - `io_addr` lies in [base, base+16).
  The access size does not matter for this window.
- R7: The decode uses the new base or enable value from the first cycle after the clock edge that performs the configuration write.
- R8: A 1 on `evt_set[i]` at a clock edge sets status bit i. The status nibble reads at byte 0x45, bits 3:0.
- R9: Writing byte 0x45 clears each status bit whose data bit is 1. If a bit is set and cleared in the same cycle, the set wins.
- R10: Byte 0x44 bits 3:0 hold the event enables. Bits 7:4 read 0.
- R11: `sci` rises one edge after (status AND enable) becomes non-zero while byte 0x3D is non-zero. It falls one edge after the last enabled status bit clears.
- R12: Byte 0x3D is writable. While it is 0, `sci` stays 0 whatever the event state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| io_strobe | input | 1 | I/O access strobe |
| io_byte | input | 1 | 1 when the I/O access is a single byte |
| io_addr | input | 16 | I/O access address |
| pm_hit | output | 1 | Access claimed by the power-management window |
| smb_hit | output | 1 | Access claimed by the SMBus window |
| evt_set | input | 4 | Event set pulses: timer, global lock, power button, RTC alarm |
| sci | output | 1 | Level system control interrupt |

## Verification
The assertions assume that `evt_set` is the only way a status bit becomes set. They also assume that a configuration write and the strobe it affects are never evaluated in the same cycle, so a hit is always judged against settled registers. The bench honours both assumptions:
- it drives every input at the falling edge;
- it samples decode outputs only after the writing edge has passed;
- it raises event pulses for exactly one cycle.

// File: rtl/pm_func_decode.sv
module pm_func_decode #(
  parameter int ADDR_W      = 16,
  parameter int PM_WIN_LOG2 = 7,
  parameter int SMB_WIN_LOG2 = 4,
  parameter int NUM_EVT     = 4,
  parameter logic [7:0] PIN_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              io_strobe,
  input  logic              io_byte,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              pm_hit,
  output logic              smb_hit,
  input  logic [NUM_EVT-1:0] evt_set,
  output logic              sci
);
  localparam int PM_BW  = ADDR_W - PM_WIN_LOG2;
  localparam int SMB_BW = ADDR_W - SMB_WIN_LOG2;
  localparam logic [ADDR_W-1:0] PM_MASK  = {{PM_BW{1'b1}}, {PM_WIN_LOG2{1'b0}}};
  localparam logic [ADDR_W-1:0] SMB_MASK = {{SMB_BW{1'b1}}, {SMB_WIN_LOG2{1'b0}}};

  localparam logic [7:0] A_PIN  = 8'h3D;
  localparam logic [7:0] A_PMEN = 8'h41;
  localparam logic [7:0] A_EVEN = 8'h44;
  localparam logic [7:0] A_STS  = 8'h45;
  localparam logic [7:0] A_PMB0 = 8'h48;
  localparam logic [7:0] A_PMB1 = 8'h49;
  localparam logic [7:0] A_SMB0 = 8'h90;
  localparam logic [7:0] A_SMB1 = 8'h91;
  localparam logic [7:0] A_SMEN = 8'hD2;

  logic [ADDR_W-1:0]  pm_base, smb_base;
  logic [7:0]         pm_ctl, int_pin;
  logic [3:0]         smb_ctl;
  logic [NUM_EVT-1:0] evt_en, evt_sts;

  wire wr = cfg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_base  <= '0;
      smb_base <= '0;
      pm_ctl   <= '0;
      smb_ctl  <= '0;
      evt_en   <= '0;
      int_pin  <= PIN_RST;
    end else if (wr) begin
      case (cfg_addr)
        A_PMB0: pm_base[7:0]  <= cfg_wdata & PM_MASK[7:0];
        A_PMB1: pm_base[15:8] <= cfg_wdata & PM_MASK[15:8];
        A_SMB0: smb_base[7:0] <= cfg_wdata & SMB_MASK[7:0];
        A_SMB1: smb_base[15:8] <= cfg_wdata & SMB_MASK[15:8];
        A_PMEN: pm_ctl  <= cfg_wdata;
        A_SMEN: smb_ctl <= cfg_wdata[3:0];
        A_EVEN: evt_en  <= cfg_wdata[NUM_EVT-1:0];
        A_PIN:  int_pin <= cfg_wdata;
        default: ;
      endcase
    end
  end

  wire [NUM_EVT-1:0] clr_mask = (wr && cfg_addr == A_STS) ? cfg_wdata[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_sts <= '0;
    else        evt_sts <= (evt_sts & ~clr_mask) | evt_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sci <= 1'b0;
    else        sci <= (int_pin != 8'h00) && ((evt_sts & evt_en) != '0);
  end

  always_comb begin
    cfg_rdata = 8'h00;
    case (cfg_addr)
      A_PMB0: cfg_rdata = (pm_base[7:0] & PM_MASK[7:0]) | 8'h01;
      A_PMB1: cfg_rdata = pm_base[15:8];
      A_SMB0: cfg_rdata = (smb_base[7:0] & SMB_MASK[7:0]) | 8'h01;
      A_SMB1: cfg_rdata = smb_base[15:8];
      A_PMEN: cfg_rdata = pm_ctl;
      A_SMEN: cfg_rdata = {4'h0, smb_ctl};
      A_EVEN: cfg_rdata = 8'(evt_en);
      A_STS:  cfg_rdata = 8'(evt_sts);
      A_PIN:  cfg_rdata = int_pin;
      default: cfg_rdata = 8'h00;
    endcase
  end

  assign pm_hit  = io_strobe && io_byte && pm_ctl[7] &&
                   ((io_addr & PM_MASK) == (pm_base & PM_MASK));
  assign smb_hit = io_strobe && smb_ctl[0] &&
                   ((io_addr & SMB_MASK) == (smb_base & SMB_MASK));

  a_r5_pm_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> (io_strobe && io_byte && pm_ctl[7]));

  a_r6_smb_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> (io_strobe && smb_ctl[0]));

  a_r8_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_sts & $past(evt_set)) == $past(evt_set)));

  a_r9_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_STS && evt_set == '0) |=>
      ((evt_sts & $past(cfg_wdata[NUM_EVT-1:0])) == '0));

  a_r11_sci_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (sci && !$isunknown(evt_sts)) |=> (!sci || (($past(evt_sts) & $past(evt_en)) != '0)));

  a_r12_pin_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pin == 8'h00 && !cfg_we) |=> !sci);
endmodule

// File: tb/pm_func_decode_test.sv
module pm_func_decode_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic        io_strobe = 0;
  logic        io_byte = 0;
  logic [15:0] io_addr = 0;
  logic        pm_hit, smb_hit;
  logic [3:0]  evt_set = 0;
  logic        sci;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pm_func_decode uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_strobe(io_strobe),
    .io_byte(io_byte), .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit),
    .evt_set(evt_set), .sci(sci)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk(req, {8'h0, cfg_rdata}, {8'h0, exp});
  endtask

  task automatic io_chk(input string req, input logic [15:0] a, input logic b,
                        input logic pe, input logic se);
    io_strobe = 1; io_byte = b; io_addr = a;
    #1;
    chk(req, {14'h0, pm_hit, smb_hit}, {14'h0, pe, se});
    io_strobe = 0;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    evt_set = e;
    @(negedge clk);
    evt_set = 0;
  endtask

  task automatic t_reset;
    rd_chk("R3 pm base low", 8'h48, 8'h01);
    rd_chk("R3 pm base high", 8'h49, 8'h00);
    rd_chk("R3 smb base low", 8'h90, 8'h01);
    rd_chk("R3 smb base high", 8'h91, 8'h00);
    rd_chk("R3 pm enable byte", 8'h41, 8'h00);
    rd_chk("R3 smb enable byte", 8'hD2, 8'h00);
    rd_chk("R3 enables", 8'h44, 8'h00);
    rd_chk("R3 status", 8'h45, 8'h00);
    rd_chk("R3 pin", 8'h3D, 8'h01);
    io_chk("R3 no hit at 0", 16'h0000, 1'b1, 1'b0, 1'b0);
    chk("R3 sci", {15'h0, sci}, 16'h0);
  endtask

  task automatic t_pm_window;
    wr(8'h48, 8'hFF);
    rd_chk("R1 low byte mask", 8'h48, 8'h81);
    wr(8'h49, 8'h12);
    rd_chk("R1 high byte", 8'h49, 8'h12);
    wr(8'h4A, 8'h55);
    rd_chk("R1 byte 0x4A zero", 8'h4A, 8'h00);
    io_chk("R5 disabled no hit", 16'h1280, 1'b1, 1'b0, 1'b0);
    wr(8'h41, 8'h80);
    io_chk("R7 enable takes effect", 16'h1280, 1'b1, 1'b1, 1'b0);
    io_chk("R5 top of window", 16'h12FF, 1'b1, 1'b1, 1'b0);
    io_chk("R5 below window", 16'h127F, 1'b1, 1'b0, 1'b0);
    io_chk("R5 above window", 16'h1300, 1'b1, 1'b0, 1'b0);
    io_chk("R5 multi-byte rejected", 16'h1280, 1'b0, 1'b0, 1'b0);
    wr(8'h49, 8'h20);
    io_chk("R7 relocated old base", 16'h1280, 1'b1, 1'b0, 1'b0);
    io_chk("R7 relocated new base", 16'h20C0, 1'b1, 1'b1, 1'b0);
    wr(8'h41, 8'h00);
    io_chk("R7 disable takes effect", 16'h20C0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_smb_window;
    wr(8'h90, 8'hAB);
    rd_chk("R2 low byte mask", 8'h90, 8'hA1);
    wr(8'h91, 8'h34);
    rd_chk("R2 high byte", 8'h91, 8'h34);
    wr(8'h92, 8'h77);
    rd_chk("R2 byte 0x92 zero", 8'h92, 8'h00);
    wr(8'hD2, 8'hF1);
    rd_chk("R4 upper nibble cleared", 8'hD2, 8'h01);
    io_chk("R6 base hit", 16'h34A0, 1'b1, 1'b0, 1'b1);
    io_chk("R6 top hit multi-byte", 16'h34AF, 1'b0, 1'b0, 1'b1);
    io_chk("R6 above window", 16'h34B0, 1'b1, 1'b0, 1'b0);
    io_chk("R6 below window", 16'h349F, 1'b1, 1'b0, 1'b0);
    wr(8'hD2, 8'h0E);
    io_chk("R6 disabled", 16'h34A0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_events;
    wr(8'h44, 8'hFF);
    rd_chk("R10 enable nibble", 8'h44, 8'h0F);
    pulse(4'b0100);
    rd_chk("R8 status set", 8'h45, 8'h04);
    chk("R11 sci not yet", {15'h0, sci}, 16'h0);
    @(negedge clk);
    chk("R11 sci rises", {15'h0, sci}, 16'h1);
    wr(8'h45, 8'h04);
    rd_chk("R9 status cleared", 8'h45, 8'h00);
    chk("R11 sci still high", {15'h0, sci}, 16'h1);
    @(negedge clk);
    chk("R11 sci falls", {15'h0, sci}, 16'h0);
    wr(8'h44, 8'h01);
    pulse(4'b1000);
    @(negedge clk);
    chk("R10 masked event quiet", {15'h0, sci}, 16'h0);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h45; cfg_wdata = 8'h0A; evt_set = 4'b0010;
    @(negedge clk);
    cfg_we = 0; evt_set = 0;
    rd_chk("R9 set beats clear", 8'h45, 8'h02);
    wr(8'h45, 8'h0F);
    wr(8'h3D, 8'h00);
    rd_chk("R12 pin write", 8'h3D, 8'h00);
    wr(8'h44, 8'h0F);
    pulse(4'b0001);
    @(negedge clk);
    @(negedge clk);
    chk("R12 pin zero suppresses", {15'h0, sci}, 16'h0);
    wr(8'h3D, 8'h01);
    @(negedge clk);
    chk("R12 pin restored", {15'h0, sci}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pm_window();
    t_smb_window();
    t_events();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule